// File: doc/BRIEF.md
# Stack Frame Save/Restore Micro-op Sequencer

This block sits behind the instruction decoder of a processor that supports compressed push and pop instructions. A push saves a list of callee-saved registers to the stack and grows the frame; a pop reloads them and shrinks it. Each request carries five fields:

- a 4-bit list code;
- a 2-bit extra-frame immediate;
- a push/pop select;
- a flag for 64-bit register width;
- a flag for the reduced-register embedded profile.

Each request also carries the current stack pointer.

The block expands one request into single-register memory micro-ops, one per cycle. They are issued from the highest-numbered saved register down to the return-address register. The last micro-op is one stack-pointer write carrying the new sp. Micro-ops leave through a valid/ready handshake. A one-cycle done pulse marks the end of a sequence. Reserved encodings produce only a one-cycle illegal flag.

The frame layout is fixed so that unwinders can parse it. The highest saved register sits just below the old sp, and ra sits in the lowest register slot. The size of the stack adjustment is the register storage rounded up to 16 bytes, plus 16 bytes per immediate step.

Top module: `rlseq_top`

## Requirements
- R1: After reset, `in_ready` is 1 and `uop_valid`, `done` and `illegal` are 0.
- R2: List code 4 selects ra alone, and each code from 5 to 14 adds one more s-register starting at s0. Code 15 selects ra and s0 through s11. Register numbers on `uop_reg` are: ra = 1, s0 = 8, s1 = 9, s2..s11 = 18..27. Memory micro-ops come from the highest selected register down to ra.
- R3: List codes 0 to 3 raise `illegal` for exactly one cycle, the cycle after acceptance. They produce no micro-op and no `done`.
- R4: With `in_embedded` set, codes 7 to 15 are treated like R3, codes 4 to 6 are legal, and the base adjustment is 16.
- R5: With 32-bit width, the adjustment is ceil(4·n/16)·16 + 16·imm, where n is the number of saved registers.
- R6: With 64-bit width (`in_xlen64`=1), slots are 8 bytes and the adjustment is ceil(8·n/16)·16 + 16·imm.
- R7: Push micro-ops have kind 0 (store). The first address is sp − slot, and each later address is one slot lower.
- R8: Pop micro-ops have kind 1 (load). The first address is sp + adjustment − slot, and each later address is one slot lower.
- R9: The last micro-op has kind 2 (sp write) and register 2. Its address field carries the new sp: sp − adjustment for push, sp + adjustment for pop.
- R10: While `uop_valid` is 1 and `uop_ready` is 0, all micro-op outputs stay unchanged.
- R11: `done` is high for one cycle, the cycle after the sp-write micro-op is accepted. It is high at no other time.
- R12: `in_ready` is 0 from acceptance until the sequence ends. A request presented during that time is ignored and produces no micro-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Sequencer idle, request accepted |
| in_code | input | 4 | Register-list code |
| in_spimm | input | 2 | Extra frame size in 16-byte steps |
| in_pop | input | 1 | 1 = pop, 0 = push |
| in_xlen64 | input | 1 | 1 = 64-bit registers |
| in_embedded | input | 1 | Embedded profile restrictions |
| in_sp | input | SPW | Current stack pointer |
| uop_valid | output | 1 | Micro-op present |
| uop_ready | input | 1 | Consumer takes micro-op |
| uop_kind | output | 2 | 0 store, 1 load, 2 sp write |
| uop_reg | output | 5 | Architectural register number |
| uop_addr | output | SPW | Memory address or new sp value |
| done | output | 1 | Sequence complete pulse |
| illegal | output | 1 | Reserved-encoding pulse |

## Verification
The bench builds the block with the default SPW of 64. This keeps full 64-bit addresses near the top of memory in play, with no truncation by the block. It switches between 32-bit and 64-bit slots and toggles the embedded flag at run time. This reaches every list code under both base tables, the 13-register list whose 64-bit base rounds 104 bytes up to 112, and the embedded rejection of longer lists. A pseudo-random ready pattern exercises the hold behaviour in the middle of each sequence and on the sp-write tail.

// File: rtl/rlseq_pkg.sv
package rlseq_pkg;
  localparam int NREG = 13;
  localparam int IDXW = $clog2(NREG);

  typedef enum logic [1:0] {
    UOP_STORE = 2'd0,
    UOP_LOAD  = 2'd1,
    UOP_SPWR  = 2'd2
  } uop_kind_e;

  // bitmap position -> architectural register number
  function automatic logic [4:0] slot_to_xreg(input logic [IDXW-1:0] s);
    case (s)
      IDXW'(0): slot_to_xreg = 5'd1;
      IDXW'(1): slot_to_xreg = 5'd8;
      IDXW'(2): slot_to_xreg = 5'd9;
      default:  slot_to_xreg = 5'(s) + 5'd15;
    endcase
  endfunction
endpackage

// File: rtl/rlseq_decode.sv
module rlseq_decode
  import rlseq_pkg::*;
(
  input  logic [3:0]      code,
  input  logic            xlen64,
  input  logic            embedded,
  output logic            legal,
  output logic [NREG-1:0] bitmap,
  output logic [7:0]      base_adj
);
  logic [3:0] nsave;
  logic [7:0] bytes;

  always_comb begin
    nsave = (code == 4'd15) ? 4'd13 : (code - 4'd3);
    legal = (code >= 4'd4) && !(embedded && (code > 4'd6));
    for (int i = 0; i < NREG; i++) begin
      bitmap[i] = legal && (i < int'(nsave));
    end
    bytes    = xlen64 ? ({4'd0, nsave} << 3) : ({4'd0, nsave} << 2);
    base_adj = embedded ? 8'd16 : ((bytes + 8'd15) & 8'hF0);
  end
endmodule

// File: rtl/rlseq_msb.sv
module rlseq_msb #(
  parameter int W = 13
) (
  input  logic [W-1:0]         vec,
  output logic [$clog2(W)-1:0] idx,
  output logic                 any
);
  localparam int IW = $clog2(W);

  always_comb begin
    idx = '0;
    any = |vec;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/rlseq_top.sv
module rlseq_top
  import rlseq_pkg::*;
#(
  parameter int SPW = 64
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [3:0]     in_code,
  input  logic [1:0]     in_spimm,
  input  logic           in_pop,
  input  logic           in_xlen64,
  input  logic           in_embedded,
  input  logic [SPW-1:0] in_sp,
  output logic           uop_valid,
  input  logic           uop_ready,
  output logic [1:0]     uop_kind,
  output logic [4:0]     uop_reg,
  output logic [SPW-1:0] uop_addr,
  output logic           done,
  output logic           illegal
);
  logic            dec_legal;
  logic [NREG-1:0] dec_bitmap;
  logic [7:0]      dec_base;

  logic [NREG-1:0] rem;
  logic [NREG-1:0] scan_in;
  logic [NREG-1:0] scan_cleared;
  logic [IDXW-1:0] top_idx;
  logic            top_any;

  logic [SPW-1:0]  nxt_addr;
  logic [SPW-1:0]  sp_final;
  logic [SPW-1:0]  slot_q;
  logic [SPW-1:0]  slot_in;
  logic [SPW-1:0]  adj_in;
  logic [SPW-1:0]  start_addr;
  logic            accept;
  logic            take;

  rlseq_decode u_dec (
    .code     (in_code),
    .xlen64   (in_xlen64),
    .embedded (in_embedded),
    .legal    (dec_legal),
    .bitmap   (dec_bitmap),
    .base_adj (dec_base)
  );

  // one scanner serves both the first pick and every later pick
  assign scan_in = uop_valid ? rem : dec_bitmap;

  rlseq_msb #(.W(NREG)) u_msb (
    .vec (scan_in),
    .idx (top_idx),
    .any (top_any)
  );

  assign scan_cleared = scan_in & ~(NREG'(1) << top_idx);

  assign in_ready   = !uop_valid;
  assign accept     = in_valid && in_ready;
  assign take       = uop_valid && uop_ready;
  assign slot_in    = in_xlen64 ? SPW'(8) : SPW'(4);
  assign adj_in     = SPW'(dec_base) + SPW'({in_spimm, 4'b0000});
  assign start_addr = (in_pop ? (in_sp + adj_in) : in_sp) - slot_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      uop_valid <= 1'b0;
      uop_kind  <= UOP_STORE;
      uop_reg   <= '0;
      uop_addr  <= '0;
      rem       <= '0;
      nxt_addr  <= '0;
      sp_final  <= '0;
      slot_q    <= '0;
      done      <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      if (accept) begin
        if (!dec_legal) begin
          illegal <= 1'b1;
        end else begin
          uop_valid <= 1'b1;
          uop_kind  <= in_pop ? UOP_LOAD : UOP_STORE;
          uop_reg   <= slot_to_xreg(top_idx);
          uop_addr  <= start_addr;
          nxt_addr  <= start_addr - slot_in;
          rem       <= scan_cleared;
          slot_q    <= slot_in;
          sp_final  <= in_pop ? (in_sp + adj_in) : (in_sp - adj_in);
        end
      end else if (take) begin
        if (uop_kind == UOP_SPWR) begin
          uop_valid <= 1'b0;
          done      <= 1'b1;
        end else if (top_any) begin
          uop_reg  <= slot_to_xreg(top_idx);
          uop_addr <= nxt_addr;
          nxt_addr <= nxt_addr - slot_q;
          rem      <= scan_cleared;
        end else begin
          uop_kind <= UOP_SPWR;
          uop_reg  <= 5'd2;
          uop_addr <= sp_final;
        end
      end
    end
  end
endmodule

// File: rtl/rlseq_chk.sv
module rlseq_chk #(
  parameter int SPW = 64
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic           uop_valid,
  input logic           uop_ready,
  input logic [1:0]     uop_kind,
  input logic [4:0]     uop_reg,
  input logic [SPW-1:0] uop_addr,
  input logic           done,
  input logic           illegal
);
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && !uop_ready) |=>
      (uop_valid && $stable(uop_addr) && $stable(uop_reg) && $stable(uop_kind)));

  a_r3_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!uop_valid && !done));

  a_r11_done_after_tail: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(uop_valid && uop_ready && uop_kind == 2'd2));

  a_r12_start_on_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(uop_valid) |-> $past(in_valid && in_ready));

  a_r7_slot_stride: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_ready && uop_kind != 2'd2) |=>
      (uop_kind == 2'd2 || uop_addr == $past(uop_addr) - SPW'(4)
                        || uop_addr == $past(uop_addr) - SPW'(8)));

  a_r9_tail_reg: assert property (@(posedge clk) disable iff (rst)
    (uop_valid && uop_kind == 2'd2) |-> (uop_reg == 5'd2));
endmodule

bind rlseq_top rlseq_chk #(.SPW(SPW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .uop_valid (uop_valid),
  .uop_ready (uop_ready),
  .uop_kind  (uop_kind),
  .uop_reg   (uop_reg),
  .uop_addr  (uop_addr),
  .done      (done),
  .illegal   (illegal)
);

// File: tb/rlseq_top_tb.sv
module rlseq_top_tb;
  localparam int SPW = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [3:0]     in_code = '0;
  logic [1:0]     in_spimm = '0;
  logic           in_pop = 1'b0;
  logic           in_xlen64 = 1'b0;
  logic           in_embedded = 1'b0;
  logic [SPW-1:0] in_sp = '0;
  logic           uop_valid;
  logic           uop_ready = 1'b1;
  logic [1:0]     uop_kind;
  logic [4:0]     uop_reg;
  logic [SPW-1:0] uop_addr;
  logic           done;
  logic           illegal;

  rlseq_top #(.SPW(SPW)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .in_spimm(in_spimm), .in_pop(in_pop),
    .in_xlen64(in_xlen64), .in_embedded(in_embedded), .in_sp(in_sp),
    .uop_valid(uop_valid), .uop_ready(uop_ready), .uop_kind(uop_kind),
    .uop_reg(uop_reg), .uop_addr(uop_addr), .done(done), .illegal(illegal)
  );

  typedef struct {
    logic [1:0]     k;
    logic [4:0]     r;
    logic [SPW-1:0] a;
    string          tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  logic ready_rand = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic logic [4:0] xreg(input int k);
    if (k == 0) return 5'd1;
    if (k == 1) return 5'd8;
    if (k == 2) return 5'd9;
    return 5'(k + 15);
  endfunction

  // consumer ready pattern, changed away from the sampling edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      uop_ready = ready_rand ? (lfsr[0] | lfsr[2]) : 1'b1;
    end
  end

  // monitor: scoreboard compare, hold check, done check
  logic           held = 1'b0;
  logic [SPW-1:0] h_addr;
  logic [6:0]     h_misc;
  logic           want_done = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      held      = 1'b0;
      want_done = 1'b0;
    end else begin
      if (want_done) chk("R11", "done after tail", 64'(done), 64'd1);
      else if (done) chk("R11", "unexpected done", 64'(done), 64'd0);
      want_done = 1'b0;
      if (held) begin
        chk("R10", "held valid", 64'(uop_valid), 64'd1);
        chk("R10", "held addr", uop_addr, h_addr);
        chk("R10", "held kind/reg", 64'({uop_kind, uop_reg}), 64'(h_misc));
      end
      held   = uop_valid && !uop_ready;
      h_addr = uop_addr;
      h_misc = {uop_kind, uop_reg};
      if (uop_valid && uop_ready) begin
        if (q.size() == 0) begin
          chk("R12", "unexpected uop", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk("R2", "register", 64'(uop_reg), 64'(e.r));
          chk("R9", "kind", 64'(uop_kind), 64'(e.k));
          chk(e.tag, "address", uop_addr, e.a);
          if (uop_kind == 2'd2) want_done = 1'b1;
        end
      end
    end
  end

  task automatic issue(input logic [3:0] code, input logic [1:0] imm,
                       input bit pop, input bit x64, input bit emb,
                       input logic [SPW-1:0] sp, input bit junk,
                       input string tag);
    bit legal;
    int n, slot, base;
    logic [SPW-1:0] adj, top;
    legal = (code >= 4) && !(emb && code > 6);
    n     = (code == 15) ? 13 : int'(code) - 3;
    slot  = x64 ? 8 : 4;
    base  = emb ? 16 : ((n * slot + 15) / 16) * 16;
    adj   = SPW'(base + int'(imm) * 16);
    top   = pop ? sp + adj : sp;
    if (legal) begin
      for (int i = 0; i < n; i++)
        q.push_back('{pop ? 2'd1 : 2'd0, xreg(n - 1 - i),
                      top - SPW'(slot * (i + 1)), tag});
      q.push_back('{2'd2, 5'd2, pop ? sp + adj : sp - adj, tag});
    end
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_code = code; in_spimm = imm; in_pop = pop;
    in_xlen64 = x64; in_embedded = emb; in_sp = sp;
    in_valid = 1'b1;
    @(negedge clk);
    if (junk) begin
      in_code = 4'd15; in_spimm = 2'd3; in_sp = '1;
    end else begin
      in_valid = 1'b0;
    end
    if (!legal) begin
      chk(tag, "illegal flag", 64'(illegal), 64'd1);
      chk(tag, "no uop on illegal", 64'(uop_valid), 64'd0);
      @(negedge clk);
      chk(tag, "illegal one cycle", 64'(illegal), 64'd0);
      chk(tag, "still no uop", 64'(uop_valid), 64'd0);
    end else begin
      while (!done) begin
        if (junk) chk("R12", "in_ready while busy", 64'(in_ready), 64'd0);
        @(negedge clk);
      end
      in_valid = 1'b0;
      chk(tag, "scoreboard drained", 64'(q.size()), 64'd0);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R11 watchdog: actual 0 expected 1 (sequence never finished)");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "in_ready", 64'(in_ready), 64'd1);
    chk("R1", "uop_valid", 64'(uop_valid), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "illegal", 64'(illegal), 64'd0);

    // 32-bit push ra,s0..s2 imm 3: s2@ffc .. ra@ff0, sp -> fc0
    issue(4'd7, 2'd3, 1'b0, 1'b0, 1'b0, 64'h1000, 1'b0, "R7");
    // 32-bit pop ra adj 16: ra@fcc, sp -> fd0
    issue(4'd4, 2'd0, 1'b1, 1'b0, 1'b0, 64'hfc0, 1'b0, "R8");
    ready_rand = 1'b1;
    issue(4'd15, 2'd1, 1'b0, 1'b1, 1'b0, 64'hffff_ffff_ffff_f000, 1'b0, "R6");
    issue(4'd14, 2'd2, 1'b1, 1'b1, 1'b0, 64'h8000_0000_0000_2000, 1'b0, "R6");
    issue(4'd11, 2'd0, 1'b0, 1'b0, 1'b0, 64'h2000, 1'b1, "R5");
    issue(4'd12, 2'd2, 1'b1, 1'b0, 1'b0, 64'h3000, 1'b1, "R5");
    for (int c = 0; c < 4; c++)
      issue(4'(c), 2'd1, c[0], c[1], 1'b0, 64'h5000, 1'b0, "R3");
    issue(4'd7, 2'd0, 1'b0, 1'b0, 1'b1, 64'h6000, 1'b0, "R4");
    issue(4'd15, 2'd3, 1'b1, 1'b0, 1'b1, 64'h6000, 1'b0, "R4");
    issue(4'd6, 2'd2, 1'b0, 1'b0, 1'b1, 64'h4000, 1'b0, "R4");
    issue(4'd5, 2'd1, 1'b1, 1'b0, 1'b1, 64'h4000, 1'b0, "R4");
    for (int c = 4; c < 16; c++) begin
      issue(4'(c), 2'(c), 1'b0, 1'b0, 1'b0, 64'h9000, 1'b0, "R5");
      issue(4'(c), 2'(c + 1), 1'b1, 1'b1, 1'b0, 64'h9000, 1'b0, "R6");
    end
    repeat (5) @(negedge clk);
    summary();
    $finish;
  end
endmodule